// File: doc/BRIEF.md
# Register Write-Enable Unlock Sequencer

This block sits behind a two-wire serial slave and decides which write transactions may change a clock/control register space. The slave front end hands it decoded bus events: a start condition, a stop condition (with the count of loose bits received after the last whole byte), and each complete byte. The first byte of a frame must be the device address, the second is the register address, and all later bytes are data. Nothing is committed until the stop arrives.

Two volatile latches guard the protected registers: a write-enable latch and a register-write-enable latch. Software opens the gate with two separate single-byte writes to the status register, first 02h and then 06h. A protected write is committed only when both latches are set and the byte count fits the addressed group. Each successful protected write closes the register-write-enable latch again, so the unlock has to be repeated. A write to the non-volatile control group starts a busy window of a set number of cycles. During that window every write is turned away. Broken frames, addresses outside the defined groups and wrong lengths leave all state as it was.

Accepted protected writes leave the block as a one-cycle commit strobe, with the group, start address, length and data bytes attached, for the register file to store.

Top module: `regwr_unlock_seq`

## Requirements
- R1: After reset, wel_o, rwel_o, busy_o and commit_o are all 0.
- R2: A frame with device byte DEh, register address 3Fh (status) and exactly one data byte 02h sets wel_o.
- R3: A status byte of 06h sets both rwel_o and wel_o only when wel_o is already 1. With wel_o at 0 it has no effect.
- R4: A status byte of 00h clears both latches. Any status byte other than 00h, 02h and 06h has no effect.
- R5: A frame whose first byte is not DEh is ignored entirely.
- R6: A clock-group write (address 30h, exactly 8 data bytes) made while both latches are set raises commit_o for one cycle, one cycle after the stop is sampled. It carries commit_grp_o=1, commit_addr_o=30h, commit_len_o=8, and data byte k (k from 0) on commit_data_o[8k+7:8k].
- R7: A control-group write (start address 10h to 14h, 1 to 5 bytes, not running past 14h) made while both latches are set commits with commit_grp_o=2. busy_o is then 1 for exactly BUSY_CYCLES cycles after the commit edge. Data bytes at index at or beyond commit_len_o are undefined.
- R8: A committed protected write clears rwel_o and leaves wel_o set.
- R9: A protected-group write without both latches set, with a wrong length, or to an undefined address commits nothing and leaves both latches unchanged.
- R10: An incomplete frame commits nothing and changes no latch, and a set rwel_o stays set. A frame is incomplete if its stop carries a nonzero loose-bit count, or if a new start arrives before its stop.
- R11: While busy_o is 1, every write is rejected, including status writes.
- R12: A frame carrying more than 8 data bytes is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start condition seen (one-cycle pulse) |
| stop_i | input | 1 | Stop condition seen (one-cycle pulse) |
| stop_frag_i | input | 3 | Bits received after the last whole byte, valid with stop_i |
| byte_vld_i | input | 1 | A whole byte was received (one-cycle pulse) |
| byte_i | input | 8 | The received byte, valid with byte_vld_i |
| wel_o | output | 1 | Write-enable latch |
| rwel_o | output | 1 | Register-write-enable latch |
| busy_o | output | 1 | Non-volatile busy window active |
| commit_o | output | 1 | One-cycle strobe for an accepted protected write |
| commit_grp_o | output | 2 | 1 = clock group, 2 = control group |
| commit_addr_o | output | 8 | Start register address of the commit |
| commit_len_o | output | 4 | Number of data bytes committed |
| commit_data_o | output | 64 | Data bytes, byte k in bits 8k+7:8k |

## Verification
The bench tries 06h before 02h. A design that did not check the order would open the gate in a single step. It sends a stop with loose bits, and also a restart in the middle of a frame. A design that committed at the wrong moment would write a half-received frame, and one that tidied up on abort would clear rwel_o. It probes each length edge: 7 and 9 clock bytes, a control write that runs one byte past the end, and a single byte at the last control address. Off-by-one range logic would accept one of the bad frames or refuse the good one. Finally it sends a status clear in the middle of the busy window and times the window's end to the exact cycle. A timer one cycle off, or a gate that let status writes through, would show as a mismatch against the model.

// File: rtl/wen_pkg.sv
package wen_pkg;

  typedef enum logic [2:0] {
    FR_IDLE = 3'd0,
    FR_DEV  = 3'd1,
    FR_ADDR = 3'd2,
    FR_DATA = 3'd3,
    FR_SKIP = 3'd4
  } fr_state_t;

  typedef enum logic [1:0] {
    GRP_NONE  = 2'd0,
    GRP_CLOCK = 2'd1,
    GRP_CTRL  = 2'd2
  } grp_t;

  localparam logic [7:0] ST_CLEAR = 8'h00;
  localparam logic [7:0] ST_ARM   = 8'h02;
  localparam logic [7:0] ST_OPEN  = 8'h06;

endpackage

// File: rtl/wen_frame_rx.sv
module wen_frame_rx
  import wen_pkg::*;
#(
  parameter int         MAX_BYTES = 8,
  parameter logic [7:0] DEV_ADDR  = 8'hDE,
  localparam int        CW        = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic                   stop_i,
  input  logic                   byte_vld_i,
  input  logic [7:0]             byte_i,
  output logic                   in_data_o,
  output logic [7:0]             addr_o,
  output logic [CW-1:0]          len_o,
  output logic                   ovf_o,
  output logic [8*MAX_BYTES-1:0] data_o
);

  fr_state_t     st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          ovf_q, ovf_n;
  logic [7:0]    addr_q, addr_n;
  logic          wr_byte;
  logic [7:0]    buf_q [MAX_BYTES];

  always_comb begin
    st_n    = st_q;
    cnt_n   = cnt_q;
    ovf_n   = ovf_q;
    addr_n  = addr_q;
    wr_byte = 1'b0;
    if (start_i) begin
      st_n  = FR_DEV;
      cnt_n = '0;
      ovf_n = 1'b0;
    end else if (stop_i) begin
      st_n = FR_IDLE;
    end else if (byte_vld_i) begin
      case (st_q)
        FR_DEV:  st_n = (byte_i == DEV_ADDR) ? FR_ADDR : FR_SKIP;
        FR_ADDR: begin
          addr_n = byte_i;
          st_n   = FR_DATA;
        end
        FR_DATA: begin
          if (cnt_q == CW'(MAX_BYTES)) begin
            ovf_n = 1'b1;
          end else begin
            wr_byte = 1'b1;
            cnt_n   = cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FR_IDLE;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      ovf_q  <= ovf_n;
      addr_q <= addr_n;
    end
  end

  for (genvar i = 0; i < MAX_BYTES; i++) begin : g_buf
    logic slot_en;
    assign slot_en = wr_byte && (cnt_q == CW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        buf_q[i] <= '0;
      end else if (slot_en) begin
        buf_q[i] <= byte_i;
      end
    end
    assign data_o[8*i +: 8] = buf_q[i];
  end

  assign in_data_o = (st_q == FR_DATA);
  assign addr_o    = addr_q;
  assign len_o     = cnt_q;
  assign ovf_o     = ovf_q;

  // R12: the byte count never passes the buffer depth
  assert_len_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(MAX_BYTES));

  // R12: once a frame overflows it stays marked until the next start
  assert_ovf_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !start_i) |=> ovf_q);

endmodule

// File: rtl/wen_busy_timer.sv
module wen_busy_timer #(
  parameter int  BUSY_CYCLES = 2000000,
  localparam int BW          = $clog2(BUSY_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic busy_o
);

  logic [BW-1:0] cnt_q, cnt_n;
  logic          cnt_en;

  assign cnt_en = load_i || (cnt_q != '0);

  always_comb begin
    if (load_i) cnt_n = BW'(BUSY_CYCLES);
    else        cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign busy_o = (cnt_q != '0);

  // R7: a control commit opens the busy window on the next cycle
  assert_busy_after_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> busy_o);

  // R11: no new window may start while one is running
  assert_no_reload_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !load_i);

endmodule

// File: rtl/wen_guard.sv
module wen_guard
  import wen_pkg::*;
#(
  parameter logic [7:0] STAT_ADDR  = 8'h3F,
  parameter logic [7:0] CLK_BASE   = 8'h30,
  parameter int         CLK_BYTES  = 8,
  parameter logic [7:0] CTRL_BASE  = 8'h10,
  parameter int         CTRL_BYTES = 5,
  parameter int         MAX_BYTES  = 8,
  localparam int        CW         = $clog2(MAX_BYTES + 1),
  localparam logic [7:0] CTRL_LAST = 8'(CTRL_BASE + CTRL_BYTES - 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   stop_i,
  input  logic [2:0]             frag_i,
  input  logic                   in_data_i,
  input  logic [7:0]             addr_i,
  input  logic [CW-1:0]          len_i,
  input  logic                   ovf_i,
  input  logic [8*MAX_BYTES-1:0] data_i,
  input  logic                   busy_i,
  output logic                   busy_load_o,
  output logic                   wel_o,
  output logic                   rwel_o,
  output logic                   commit_o,
  output logic [1:0]             grp_o,
  output logic [7:0]             caddr_o,
  output logic [CW-1:0]          clen_o,
  output logic [8*MAX_BYTES-1:0] cdata_o
);

  logic       frame_ok, is_stat, is_clk, is_ctrl, stat_hit, prot_ok;
  logic [8:0] ctrl_end;
  logic [7:0] first_byte;
  logic       wel_n, rwel_n;
  grp_t       grp_n;

  assign first_byte = data_i[7:0];
  assign ctrl_end   = {1'b0, addr_i} - {1'b0, CTRL_BASE} + 9'(len_i);

  always_comb begin
    frame_ok = stop_i && in_data_i && (frag_i == 3'd0) && !ovf_i && !busy_i
               && (len_i != '0);
    is_stat  = (addr_i == STAT_ADDR) && (len_i == CW'(1));
    is_clk   = (addr_i == CLK_BASE) && (len_i == CW'(CLK_BYTES));
    is_ctrl  = (addr_i >= CTRL_BASE) && (addr_i <= CTRL_LAST)
               && (ctrl_end <= 9'(CTRL_BYTES));
    stat_hit = frame_ok && is_stat;
    prot_ok  = frame_ok && wel_o && rwel_o && (is_clk || is_ctrl);
  end

  always_comb begin
    wel_n  = wel_o;
    rwel_n = rwel_o;
    grp_n  = GRP_NONE;
    if (stat_hit) begin
      case (first_byte)
        ST_CLEAR: begin
          wel_n  = 1'b0;
          rwel_n = 1'b0;
        end
        ST_ARM:  wel_n = 1'b1;
        ST_OPEN: begin
          if (wel_o) begin
            wel_n  = 1'b1;
            rwel_n = 1'b1;
          end
        end
        default: ;
      endcase
    end else if (prot_ok) begin
      rwel_n = 1'b0;
      grp_n  = is_clk ? GRP_CLOCK : GRP_CTRL;
    end
  end

  assign busy_load_o = prot_ok && is_ctrl && !is_clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_o    <= 1'b0;
      rwel_o   <= 1'b0;
      commit_o <= 1'b0;
    end else begin
      wel_o    <= wel_n;
      rwel_o   <= rwel_n;
      commit_o <= prot_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_o   <= '0;
      caddr_o <= '0;
      clen_o  <= '0;
      cdata_o <= '0;
    end else if (prot_ok) begin
      grp_o   <= grp_n;
      caddr_o <= addr_i;
      clen_o  <= len_i;
      cdata_o <= data_i;
    end
  end

  // R6: a commit only follows a cycle with both latches set
  assert_commit_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> $past(wel_o && rwel_o));

  // R8: a commit closes the register gate and keeps the first latch
  assert_commit_relocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> (!rwel_o && wel_o));

  // R3: the register gate can only open on top of the first latch
  assert_open_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rwel_o) |-> $past(wel_o));

  // R11: nothing commits out of a busy cycle
  assert_no_commit_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> !$past(busy_i));

  // R11: latches are frozen while busy
  assert_latch_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> ($stable(wel_o) && $stable(rwel_o)));

endmodule

// File: rtl/regwr_unlock_seq.sv
module regwr_unlock_seq #(
  parameter logic [7:0] DEV_ADDR    = 8'hDE,
  parameter logic [7:0] STAT_ADDR   = 8'h3F,
  parameter logic [7:0] CLK_BASE    = 8'h30,
  parameter int         CLK_BYTES   = 8,
  parameter logic [7:0] CTRL_BASE   = 8'h10,
  parameter int         CTRL_BYTES  = 5,
  parameter int         BUSY_CYCLES = 2000000,
  localparam int        MAX_BYTES   = (CLK_BYTES > CTRL_BYTES) ? CLK_BYTES : CTRL_BYTES,
  localparam int        LW          = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic                   stop_i,
  input  logic [2:0]             stop_frag_i,
  input  logic                   byte_vld_i,
  input  logic [7:0]             byte_i,
  output logic                   wel_o,
  output logic                   rwel_o,
  output logic                   busy_o,
  output logic                   commit_o,
  output logic [1:0]             commit_grp_o,
  output logic [7:0]             commit_addr_o,
  output logic [LW-1:0]          commit_len_o,
  output logic [8*MAX_BYTES-1:0] commit_data_o
);

  logic                   rst_meta_q, rst_sync_q;
  logic                   in_data;
  logic [7:0]             fr_addr;
  logic [LW-1:0]          fr_len;
  logic                   fr_ovf;
  logic [8*MAX_BYTES-1:0] fr_data;
  logic                   busy_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  wen_frame_rx #(
    .MAX_BYTES (MAX_BYTES),
    .DEV_ADDR  (DEV_ADDR)
  ) u_rx (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .byte_vld_i (byte_vld_i),
    .byte_i     (byte_i),
    .in_data_o  (in_data),
    .addr_o     (fr_addr),
    .len_o      (fr_len),
    .ovf_o      (fr_ovf),
    .data_o     (fr_data)
  );

  wen_guard #(
    .STAT_ADDR  (STAT_ADDR),
    .CLK_BASE   (CLK_BASE),
    .CLK_BYTES  (CLK_BYTES),
    .CTRL_BASE  (CTRL_BASE),
    .CTRL_BYTES (CTRL_BYTES),
    .MAX_BYTES  (MAX_BYTES)
  ) u_guard (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .stop_i      (stop_i),
    .frag_i      (stop_frag_i),
    .in_data_i   (in_data),
    .addr_i      (fr_addr),
    .len_i       (fr_len),
    .ovf_i       (fr_ovf),
    .data_i      (fr_data),
    .busy_i      (busy_o),
    .busy_load_o (busy_load),
    .wel_o       (wel_o),
    .rwel_o      (rwel_o),
    .commit_o    (commit_o),
    .grp_o       (commit_grp_o),
    .caddr_o     (commit_addr_o),
    .clen_o      (commit_len_o),
    .cdata_o     (commit_data_o)
  );

  wen_busy_timer #(
    .BUSY_CYCLES (BUSY_CYCLES)
  ) u_busy (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .load_i (busy_load),
    .busy_o (busy_o)
  );

endmodule

// File: tb/regwr_unlock_seq_bench.sv
module regwr_unlock_seq_bench;

  localparam int BUSY = 50;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, stop_i = 1'b0, byte_vld_i = 1'b0;
  logic [2:0]  stop_frag_i = 3'd0;
  logic [7:0]  byte_i = 8'h00;
  logic        wel_o, rwel_o, busy_o, commit_o;
  logic [1:0]  commit_grp_o;
  logic [7:0]  commit_addr_o;
  logic [3:0]  commit_len_o;
  logic [63:0] commit_data_o;

  int checks = 0, failures = 0, commits_seen = 0, cycles = 0;
  string cur_req = "R1";
  logic [7:0] pl [16];

  always #5 clk = ~clk;

  regwr_unlock_seq #(.BUSY_CYCLES(BUSY)) u_regwr_unlock_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .stop_frag_i(stop_frag_i), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
    .wel_o(wel_o), .rwel_o(rwel_o), .busy_o(busy_o), .commit_o(commit_o),
    .commit_grp_o(commit_grp_o), .commit_addr_o(commit_addr_o),
    .commit_len_o(commit_len_o), .commit_data_o(commit_data_o)
  );

  // behavioural reference model
  bit         m_wel, m_rwel, m_commit;
  int         m_busy, m_phase, m_grp, m_len;
  logic [7:0] m_addr, m_caddr;
  logic [7:0] q [$];
  logic [7:0] m_cdata [$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_wel = 0; m_rwel = 0; m_commit = 0; m_busy = 0; m_phase = 0;
      m_grp = 0; m_len = 0; q.delete();
    end else begin
      bit busy_now, load;
      busy_now = (m_busy > 0);
      load = 0;
      m_commit = 0;
      if (start_i) begin
        m_phase = 1; q.delete();
      end else if (stop_i) begin
        if (m_phase == 3 && stop_frag_i == 0 && q.size() >= 1 && q.size() <= 8 && !busy_now) begin
          int a, n;
          a = int'(m_addr); n = q.size();
          if (a == 8'h3F && n == 1) begin
            if (q[0] == 8'h00) begin m_wel = 0; m_rwel = 0; end
            else if (q[0] == 8'h02) m_wel = 1;
            else if (q[0] == 8'h06 && m_wel) begin m_wel = 1; m_rwel = 1; end
          end else if (m_wel && m_rwel &&
                       ((a == 8'h30 && n == 8) || (a >= 8'h10 && a + n <= 8'h15))) begin
            m_commit = 1; m_rwel = 0;
            m_grp = (a == 8'h30) ? 1 : 2;
            m_caddr = m_addr; m_len = n; m_cdata = q;
            load = (m_grp == 2);
          end
        end
        m_phase = 0;
      end else if (byte_vld_i) begin
        if (m_phase == 1) m_phase = (byte_i == 8'hDE) ? 2 : 4;
        else if (m_phase == 2) begin m_addr = byte_i; m_phase = 3; end
        else if (m_phase == 3) q.push_back(byte_i);
      end
      if (load) m_busy = BUSY;
      else if (m_busy > 0) m_busy = m_busy - 1;
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk(cur_req, "wel", 64'(wel_o), 64'(m_wel));
      chk(cur_req, "rwel", 64'(rwel_o), 64'(m_rwel));
      chk(cur_req, "busy", 64'(busy_o), 64'(m_busy > 0));
      chk(cur_req, "commit", 64'(commit_o), 64'(m_commit));
      if (commit_o) begin
        commits_seen++;
        if (m_commit) begin
          chk(cur_req, "grp", 64'(commit_grp_o), 64'(m_grp));
          chk(cur_req, "addr", 64'(commit_addr_o), 64'(m_caddr));
          chk(cur_req, "len", 64'(commit_len_o), 64'(m_len));
          for (int k = 0; k < m_len; k++)
            chk(cur_req, "data", 64'(commit_data_o[8*k +: 8]), 64'(m_cdata[k]));
        end
      end
    end
  end

  task automatic p_start();
    @(negedge clk); start_i = 1'b1; @(negedge clk); start_i = 1'b0;
  endtask
  task automatic p_stop(input logic [2:0] frag);
    @(negedge clk); stop_i = 1'b1; stop_frag_i = frag;
    @(negedge clk); stop_i = 1'b0; stop_frag_i = 3'd0;
  endtask
  task automatic p_byte(input logic [7:0] b);
    @(negedge clk); byte_vld_i = 1'b1; byte_i = b; @(negedge clk); byte_vld_i = 1'b0;
  endtask
  task automatic frame(input logic [7:0] dev, input logic [7:0] addr, input int n, input logic [2:0] frag);
    p_start(); p_byte(dev); p_byte(addr);
    for (int k = 0; k < n; k++) p_byte(pl[k]);
    p_stop(frag);
    repeat (2) @(negedge clk);
  endtask
  task automatic stat(input logic [7:0] v);
    pl[0] = v; frame(8'hDE, 8'h3F, 1, 3'd0);
  endtask
  task automatic fill(input int base);
    for (int k = 0; k < 16; k++) pl[k] = 8'(base + 17 * k);
  endtask

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "wel", 64'(wel_o), 0); chk("R1", "rwel", 64'(rwel_o), 0);
    chk("R1", "busy", 64'(busy_o), 0); chk("R1", "commit", 64'(commit_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    cur_req = "R5"; pl[0] = 8'h02; frame(8'hDC, 8'h3F, 1, 3'd0);
    chk("R5", "wel after foreign device byte", 64'(wel_o), 0);

    cur_req = "R3"; stat(8'h06);
    chk("R3", "rwel after early 06h", 64'(rwel_o), 0);
    cur_req = "R2"; stat(8'h02);
    chk("R2", "wel after 02h", 64'(wel_o), 1);
    cur_req = "R4"; stat(8'h04);
    chk("R4", "wel after 04h", 64'(wel_o), 1);
    stat(8'h00);
    chk("R4", "wel after 00h", 64'(wel_o), 0);
    stat(8'h02);
    cur_req = "R3"; stat(8'h06);
    chk("R3", "rwel after 02h then 06h", 64'(rwel_o), 1);

    cur_req = "R10"; c0 = commits_seen; fill(8'h21);
    frame(8'hDE, 8'h30, 8, 3'd3);
    p_start(); p_byte(8'hDE); p_byte(8'h30); p_byte(8'h11); p_byte(8'h22);
    p_start(); p_stop(3'd0); repeat (2) @(negedge clk);
    chk("R10", "commits after broken frames", 64'(commits_seen - c0), 0);
    chk("R10", "rwel kept", 64'(rwel_o), 1);

    cur_req = "R9"; frame(8'hDE, 8'h30, 7, 3'd0);
    pl[0] = 8'h5A; frame(8'hDE, 8'h50, 1, 3'd0);
    chk("R9", "commits after bad length/addr", 64'(commits_seen - c0), 0);
    chk("R9", "rwel kept", 64'(rwel_o), 1);

    cur_req = "R12"; frame(8'hDE, 8'h30, 9, 3'd0);
    chk("R12", "commits after 9 bytes", 64'(commits_seen - c0), 0);

    cur_req = "R6"; fill(8'h40); frame(8'hDE, 8'h30, 8, 3'd0);
    chk("R6", "clock commit count", 64'(commits_seen - c0), 1);
    cur_req = "R8";
    chk("R8", "rwel after commit", 64'(rwel_o), 0);
    chk("R8", "wel after commit", 64'(wel_o), 1);

    cur_req = "R9"; frame(8'hDE, 8'h30, 8, 3'd0);
    chk("R9", "commit with rwel low", 64'(commits_seen - c0), 1);

    cur_req = "R9"; stat(8'h06); fill(8'h03); frame(8'hDE, 8'h13, 3, 3'd0);
    chk("R9", "commit past control end", 64'(commits_seen - c0), 1);

    cur_req = "R7"; frame(8'hDE, 8'h12, 3, 3'd0);
    chk("R7", "control commit count", 64'(commits_seen - c0), 2);
    chk("R7", "busy raised", 64'(busy_o), 1);

    cur_req = "R11"; stat(8'h00);
    chk("R11", "wel kept during busy", 64'(wel_o), 1);
    stat(8'h06);
    chk("R11", "rwel kept low during busy", 64'(rwel_o), 0);
    cur_req = "R7"; repeat (BUSY) @(negedge clk);
    chk("R7", "busy ended", 64'(busy_o), 0);

    cur_req = "R7"; stat(8'h06); pl[0] = 8'hC3; frame(8'hDE, 8'h14, 1, 3'd0);
    chk("R7", "single byte at last control addr", 64'(commits_seen - c0), 3);
    repeat (BUSY + 4) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule